// File: doc/BRIEF.md
# Dual Shadow Branch Buffer

This block is a small fallback store for branches that the front end found by decoding the unused bytes of instruction lines it had already fetched. These branches were never committed to the main branch target buffer. The store has two type-specific halves. One half holds direct unconditional branches together with their targets. The other half holds only the locations of return instructions. Both halves are filled solely by the shadow decoder's insert port, so they never displace entries in the main target buffer.

The branch prediction unit presents each fetch address to this block in the same cycle that it probes its main target buffer, and it passes that buffer's hit and target alongside. The block resolves the result in the same cycle. A main-buffer hit always wins. Otherwise a direct-branch hit supplies a target. A return hit tells the predictor to pop its return address stack. This keeps speculation on the right path when the main buffer misses.

Top module: `shadow_branch_buf`

## Requirements
- R1: After reset, every entry in both halves is invalid, and every lookup with `btb_hit_i`=0 gives `pred_hit_o`=0, `pred_src_o`=2'b00, `pred_target_o`=0 and `ras_pop_o`=0.
- R2: An insert with `ins_kind_i`=0 (direct) accepted at a clock edge is visible to lookups from the following cycle. Such a lookup gives `pred_hit_o`=1, `pred_src_o`=2'b10, and the stored target on `pred_target_o`.
- R3: An insert with `ins_kind_i`=1 (return) makes later lookups of that address give `pred_hit_o`=1, `pred_src_o`=2'b11, `ras_pop_o`=1 and `pred_target_o`=0.
- R4: A lookup is combinational within the cycle. An insert and a lookup of the same address in the same cycle miss in that cycle and hit in the next cycle.
- R5: When `btb_hit_i`=1, the outputs are `pred_hit_o`=1, `pred_src_o`=2'b01, `pred_target_o`=`btb_target_i` and `ras_pop_o`=0, whatever the store holds.
- R6: The direct half has 16 sets of 4 ways. Its set is pc[3:0] and its partial tag is pc[11:4]. The return half has 8 sets of 2 ways. Its set is pc[2:0] and its partial tag is pc[10:3]. Address bits above the tag are ignored, so aliasing addresses hit.
- R7: An insert that matches no entry fills the lowest-numbered invalid way of its set. If the set is full, it replaces the way least recently filled or refreshed.
- R8: Inserting an address already held in that half overwrites its target and makes it most recent. It does not create a second entry.
- R9: An address is held in at most one half. Inserting it as one kind removes a matching entry from the other half.
- R10: A flush clears every valid bit in one cycle. An insert in the same cycle as a flush is dropped.
- R11: Sets are independent. All 64 direct entries and all 16 return entries can be held at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Invalidate all entries |
| ins_valid_i | input | 1 | Insert request from the shadow decoder |
| ins_kind_i | input | 1 | 0 = direct unconditional, 1 = return |
| ins_pc_i | input | 32 | Address of the inserted branch |
| ins_target_i | input | 32 | Target of a direct branch |
| lkp_pc_i | input | 32 | Fetch address under prediction |
| btb_hit_i | input | 1 | Main target buffer hit for `lkp_pc_i` |
| btb_target_i | input | 32 | Main target buffer target |
| pred_hit_o | output | 1 | Some source identified a branch |
| pred_src_o | output | 2 | 00 none, 01 main buffer, 10 shadow direct, 11 shadow return |
| pred_target_o | output | 32 | Predicted target, 0 for return or none |
| ras_pop_o | output | 1 | Pop the return address stack |

## Verification
The direct half is filled completely with arithmetic address and target patterns, and every entry is read back. The return half is filled and read back the same way. This separates index and tag slicing faults from target storage faults. A single set is driven through overflow, refresh and a further overflow. This makes the choice of victim observable, and it distinguishes true recency order from FIFO order and from duplicated entries. Further directed patterns probe the main-buffer override, addresses that differ only above the tag, moving an address from one kind to the other, a same-cycle insert and lookup, and a flush that meets an insert.

// File: rtl/sbb_pkg.sv
package sbb_pkg;
  typedef enum logic [1:0] {
    SRC_NONE = 2'b00,
    SRC_BTB  = 2'b01,
    SRC_DIR  = 2'b10,
    SRC_RET  = 2'b11
  } pred_src_e;

  typedef enum logic {
    KIND_DIR = 1'b0,
    KIND_RET = 1'b1
  } br_kind_e;
endpackage

// File: rtl/sbb_lru.sv
module sbb_lru #(
  parameter int WAYS = 4,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             touch_i,
  input  logic [WAY_W-1:0] touch_way_i,
  output logic [WAY_W-1:0] victim_o
);
  // age 0 = most recent, WAYS-1 = victim; ages always form a permutation
  logic [WAY_W-1:0] age_q [WAYS];
  logic [WAYS-1:0]  oldest;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int w = 0; w < WAYS; w++) age_q[w] <= WAY_W'(w);
    end else if (touch_i) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == touch_way_i)            age_q[w] <= '0;
        else if (age_q[w] < age_q[touch_way_i])  age_q[w] <= age_q[w] + 1'b1;
      end
    end
  end

  always_comb begin
    victim_o = '0;
    for (int w = 0; w < WAYS; w++) begin
      oldest[w] = (age_q[w] == WAY_W'(WAYS - 1));
      if (oldest[w]) victim_o = WAY_W'(w);
    end
  end

  // R7
  single_victim_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(oldest) == 1);

  // R7
  touched_not_victim_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    touch_i |=> victim_o != $past(touch_way_i));
endmodule

// File: rtl/sbb_store.sv
module sbb_store #(
  parameter int  PC_W      = 32,
  parameter int  SETS      = 16,
  parameter int  WAYS      = 4,
  parameter int  TAG_W     = 8,
  parameter int  TGT_W     = 32,
  parameter bit  STORE_TGT = 1'b1,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             wr_i,
  input  logic             inv_i,
  input  logic [PC_W-1:0]  wr_pc_i,
  input  logic [TGT_W-1:0] wr_tgt_i,
  input  logic [PC_W-1:0]  rd_pc_i,
  output logic             hit_o,
  output logic [TGT_W-1:0] tgt_o
);
  logic [IDX_W-1:0] wr_idx, rd_idx;
  logic [TAG_W-1:0] wr_tag, rd_tag;
  logic [WAYS-1:0]  valid_q [SETS];
  logic [TAG_W-1:0] tag_q   [SETS][WAYS];
  logic [WAYS-1:0]  wr_match, rd_match;
  logic [WAY_W-1:0] fill_way;
  logic [WAY_W-1:0] victim_w [SETS];
  logic             found;
  logic             do_wr;
  logic             unused_pc;

  assign wr_idx    = wr_pc_i[IDX_W-1:0];
  assign wr_tag    = wr_pc_i[IDX_W +: TAG_W];
  assign rd_idx    = rd_pc_i[IDX_W-1:0];
  assign rd_tag    = rd_pc_i[IDX_W +: TAG_W];
  assign do_wr     = wr_i && !flush_i;
  assign unused_pc = ^{wr_pc_i, rd_pc_i};

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      wr_match[w] = valid_q[wr_idx][w] && (tag_q[wr_idx][w] == wr_tag);
      rd_match[w] = valid_q[rd_idx][w] && (tag_q[rd_idx][w] == rd_tag);
    end
  end
  assign hit_o = |rd_match;

  // refresh on match, else first invalid way, else LRU victim
  always_comb begin
    fill_way = '0;
    found    = 1'b0;
    for (int w = 0; w < WAYS; w++) begin
      if (!found && wr_match[w]) begin
        fill_way = WAY_W'(w);
        found    = 1'b1;
      end
    end
    for (int w = 0; w < WAYS; w++) begin
      if (!found && !valid_q[wr_idx][w]) begin
        fill_way = WAY_W'(w);
        found    = 1'b1;
      end
    end
    if (!found) fill_way = victim_w[wr_idx];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) tag_q[s][w] <= '0;
      end
    end else if (flush_i) begin
      for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
    end else if (wr_i) begin
      valid_q[wr_idx][fill_way] <= 1'b1;
      tag_q[wr_idx][fill_way]   <= wr_tag;
    end else if (inv_i) begin
      valid_q[wr_idx] <= valid_q[wr_idx] & ~wr_match;
    end
  end

  for (genvar s = 0; s < SETS; s++) begin : g_lru
    sbb_lru #(.WAYS(WAYS)) u_lru (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .touch_i     (do_wr && (wr_idx == IDX_W'(s))),
      .touch_way_i (fill_way),
      .victim_o    (victim_w[s])
    );
  end

  if (STORE_TGT) begin : g_tgt
    logic [TGT_W-1:0] tgt_q [SETS][WAYS];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int s = 0; s < SETS; s++)
          for (int w = 0; w < WAYS; w++) tgt_q[s][w] <= '0;
      end else if (do_wr) begin
        tgt_q[wr_idx][fill_way] <= wr_tgt_i;
      end
    end
    always_comb begin
      tgt_o = '0;
      for (int w = 0; w < WAYS; w++)
        if (rd_match[w]) tgt_o = tgt_o | tgt_q[rd_idx][w];
    end
  end else begin : g_no_tgt
    logic unused_tgt;
    assign unused_tgt = ^wr_tgt_i;
    assign tgt_o      = '0;
  end

  // R8
  no_dup_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(rd_match));

  // R9
  wr_inv_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && inv_i));

  // R10
  flush_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !hit_o);

  // R2
  wr_lands_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    do_wr |=> valid_q[$past(wr_idx)][$past(fill_way)]);
endmodule

// File: rtl/shadow_branch_buf.sv
module shadow_branch_buf
  import sbb_pkg::*;
#(
  parameter int PC_W     = 32,
  parameter int DIR_SETS = 16,
  parameter int DIR_WAYS = 4,
  parameter int RET_SETS = 8,
  parameter int RET_WAYS = 2,
  parameter int TAG_W    = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            flush_i,
  input  logic            ins_valid_i,
  input  logic            ins_kind_i,
  input  logic [PC_W-1:0] ins_pc_i,
  input  logic [PC_W-1:0] ins_target_i,
  input  logic [PC_W-1:0] lkp_pc_i,
  input  logic            btb_hit_i,
  input  logic [PC_W-1:0] btb_target_i,
  output logic            pred_hit_o,
  output logic [1:0]      pred_src_o,
  output logic [PC_W-1:0] pred_target_o,
  output logic            ras_pop_o
);
  br_kind_e        kind;
  logic            dir_hit, ret_hit;
  logic [PC_W-1:0] dir_tgt, ret_tgt_unused;
  pred_src_e       src;

  assign kind = br_kind_e'(ins_kind_i);

  sbb_store #(
    .PC_W(PC_W), .SETS(DIR_SETS), .WAYS(DIR_WAYS), .TAG_W(TAG_W),
    .TGT_W(PC_W), .STORE_TGT(1'b1)
  ) u_dir (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .flush_i  (flush_i),
    .wr_i     (ins_valid_i && kind == KIND_DIR),
    .inv_i    (ins_valid_i && kind == KIND_RET),
    .wr_pc_i  (ins_pc_i),
    .wr_tgt_i (ins_target_i),
    .rd_pc_i  (lkp_pc_i),
    .hit_o    (dir_hit),
    .tgt_o    (dir_tgt)
  );

  sbb_store #(
    .PC_W(PC_W), .SETS(RET_SETS), .WAYS(RET_WAYS), .TAG_W(TAG_W),
    .TGT_W(PC_W), .STORE_TGT(1'b0)
  ) u_ret (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .flush_i  (flush_i),
    .wr_i     (ins_valid_i && kind == KIND_RET),
    .inv_i    (ins_valid_i && kind == KIND_DIR),
    .wr_pc_i  (ins_pc_i),
    .wr_tgt_i (ins_target_i),
    .rd_pc_i  (lkp_pc_i),
    .hit_o    (ret_hit),
    .tgt_o    (ret_tgt_unused)
  );

  // main buffer first, then shadow direct, then shadow return
  always_comb begin
    src           = SRC_NONE;
    pred_target_o = '0;
    if (btb_hit_i) begin
      src           = SRC_BTB;
      pred_target_o = btb_target_i;
    end else if (dir_hit) begin
      src           = SRC_DIR;
      pred_target_o = dir_tgt;
    end else if (ret_hit) begin
      src           = SRC_RET;
    end
  end

  assign pred_src_o = src;
  assign pred_hit_o = (src != SRC_NONE);
  assign ras_pop_o  = (src == SRC_RET);

  // R5
  btb_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    btb_hit_i |-> (pred_src_o == 2'b01) && (pred_target_o == btb_target_i) && !ras_pop_o);

  // R3
  ret_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ras_pop_o |-> ret_hit && !dir_hit && !btb_hit_i && (pred_target_o == '0));

  // R1
  miss_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!btb_hit_i && !dir_hit && !ret_hit) |-> !pred_hit_o && (pred_target_o == '0));
endmodule

// File: tb/sim_shadow_branch_buf.sv
module sim_shadow_branch_buf;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        flush_i = 1'b0;
  logic        ins_valid_i = 1'b0;
  logic        ins_kind_i = 1'b0;
  logic [31:0] ins_pc_i = '0;
  logic [31:0] ins_target_i = '0;
  logic [31:0] lkp_pc_i = '0;
  logic        btb_hit_i = 1'b0;
  logic [31:0] btb_target_i = '0;
  logic        pred_hit_o;
  logic [1:0]  pred_src_o;
  logic [31:0] pred_target_o;
  logic        ras_pop_o;

  int total = 0;
  int bad = 0;

  always #5 clk_i = ~clk_i;

  shadow_branch_buf u0 (.*);

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ins(input logic kind, input logic [31:0] pc, input logic [31:0] tgt);
    @(negedge clk_i);
    ins_valid_i = 1'b1; ins_kind_i = kind; ins_pc_i = pc; ins_target_i = tgt;
    @(negedge clk_i);
    ins_valid_i = 1'b0;
  endtask

  task automatic flush();
    @(negedge clk_i);
    flush_i = 1'b1;
    @(negedge clk_i);
    flush_i = 1'b0;
  endtask

  task automatic look(input logic [31:0] pc, input logic b, input logic [31:0] bt);
    lkp_pc_i = pc; btb_hit_i = b; btb_target_i = bt;
    #1;
  endtask

  task automatic exp_dir(input string req, input logic [31:0] pc, input logic [31:0] tgt);
    look(pc, 1'b0, '0);
    check(req, {pred_hit_o, pred_src_o, ras_pop_o, pred_target_o}, {1'b1, 2'b10, 1'b0, tgt});
  endtask

  task automatic exp_ret(input string req, input logic [31:0] pc);
    look(pc, 1'b0, '0);
    check(req, {pred_hit_o, pred_src_o, ras_pop_o, pred_target_o}, {1'b1, 2'b11, 1'b1, 32'h0});
  endtask

  task automatic exp_miss(input string req, input logic [31:0] pc);
    look(pc, 1'b0, '0);
    check(req, {pred_hit_o, pred_src_o, ras_pop_o, pred_target_o}, {1'b0, 2'b00, 1'b0, 32'h0});
  endtask

  function automatic logic [31:0] dpc(input int tag, input int set);
    return 32'((tag << 4) | set);
  endfunction

  function automatic logic [31:0] rpc(input int tag, input int set);
    return 32'((tag << 3) | set);
  endfunction

  initial begin
    #(200000 * 10);
    bad++;
    total++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1: empty after reset
    for (int p = 0; p < 128; p++) exp_miss("R1 reset", 32'(p * 7));

    // R11 R2 R6: fill every direct way of every set
    for (int s = 0; s < 16; s++)
      for (int w = 0; w < 4; w++) ins(1'b0, dpc(w * 5 + 1, s), dpc(w * 5 + 1, s) * 3 + 32'h100);
    @(negedge clk_i);
    for (int s = 0; s < 16; s++)
      for (int w = 0; w < 4; w++) exp_dir("R11 dir sweep", dpc(w * 5 + 1, s), dpc(w * 5 + 1, s) * 3 + 32'h100);

    // R6: bits above the tag are ignored
    exp_dir("R6 alias", dpc(6, 9) | 32'h0000_1000, dpc(6, 9) * 3 + 32'h100);
    exp_dir("R6 alias high", dpc(16, 2) | 32'hF000_0000, dpc(16, 2) * 3 + 32'h100);
    exp_miss("R6 tag differs", dpc(2, 9));

    // R5: main buffer overrides a shadow hit and a miss
    look(dpc(1, 3), 1'b1, 32'hCAFE_0000);
    check("R5 btb over dir", {pred_hit_o, pred_src_o, ras_pop_o, pred_target_o}, {1'b1, 2'b01, 1'b0, 32'hCAFE_0000});
    look(32'h0000_0FF0, 1'b1, 32'h1234_5678);
    check("R5 btb alone", {pred_hit_o, pred_src_o, ras_pop_o, pred_target_o}, {1'b1, 2'b01, 1'b0, 32'h1234_5678});

    // R10: flush empties everything
    flush();
    for (int s = 0; s < 16; s++) exp_miss("R10 flush", dpc(1, s));

    // R11 R3: fill every return way
    for (int s = 0; s < 8; s++)
      for (int w = 0; w < 2; w++) ins(1'b1, rpc(w * 9 + 2, s), 32'hFFFF_FFFF);
    for (int s = 0; s < 8; s++)
      for (int w = 0; w < 2; w++) exp_ret("R3 ret sweep", rpc(w * 9 + 2, s));
    exp_ret("R6 ret alias", rpc(2, 4) | 32'h0000_0800);
    look(rpc(2, 4), 1'b1, 32'h0000_0ABC);
    check("R5 btb over ret", {pred_hit_o, pred_src_o, ras_pop_o, pred_target_o}, {1'b1, 2'b01, 1'b0, 32'h0000_0ABC});
    flush();

    // R7 R8: recency within direct set 5
    for (int t = 0; t < 5; t++) ins(1'b0, dpc(t + 32, 5), 32'(t + 32'h500));
    exp_miss("R7 oldest evicted", dpc(32, 5));
    for (int t = 1; t < 5; t++) exp_dir("R7 survivors", dpc(t + 32, 5), 32'(t + 32'h500));
    ins(1'b0, dpc(33, 5), 32'h0000_7777);
    exp_dir("R8 refresh target", dpc(33, 5), 32'h0000_7777);
    ins(1'b0, dpc(40, 5), 32'h0000_0540);
    exp_miss("R7 lru after refresh", dpc(34, 5));
    exp_dir("R8 refreshed kept", dpc(33, 5), 32'h0000_7777);
    exp_dir("R7 kept 35", dpc(35, 5), 32'h503);
    exp_dir("R7 kept 36", dpc(36, 5), 32'h504);
    exp_dir("R7 new", dpc(40, 5), 32'h540);

    // R8: repeated insert does not duplicate
    flush();
    for (int k = 0; k < 5; k++) ins(1'b0, dpc(50, 11), 32'(k));
    for (int t = 0; t < 3; t++) ins(1'b0, dpc(60 + t, 11), 32'(t + 32'h60));
    exp_dir("R8 no dup", dpc(50, 11), 32'h4);
    for (int t = 0; t < 3; t++) exp_dir("R8 others", dpc(60 + t, 11), 32'(t + 32'h60));

    // R9: moving an address between kinds
    flush();
    ins(1'b0, 32'h0000_0217, 32'h0000_9000);
    ins(1'b1, 32'h0000_0217, 32'h0);
    exp_ret("R9 dir to ret", 32'h0000_0217);
    ins(1'b0, 32'h0000_0217, 32'h0000_9100);
    exp_dir("R9 ret to dir", 32'h0000_0217, 32'h0000_9100);
    for (int t = 0; t < 4; t++) ins(1'b0, dpc(48 + t, 7), 32'h0);
    exp_miss("R9 ret removed", 32'h0000_0217);

    // R4: same-cycle insert and lookup
    @(negedge clk_i);
    ins_valid_i = 1'b1; ins_kind_i = 1'b0; ins_pc_i = dpc(70, 13); ins_target_i = 32'h0000_ABCD;
    exp_miss("R4 same cycle", dpc(70, 13));
    @(negedge clk_i);
    ins_valid_i = 1'b0;
    exp_dir("R4 next cycle", dpc(70, 13), 32'h0000_ABCD);

    // R10: flush beats concurrent insert
    @(negedge clk_i);
    flush_i = 1'b1; ins_valid_i = 1'b1; ins_kind_i = 1'b1; ins_pc_i = rpc(5, 1);
    @(negedge clk_i);
    flush_i = 1'b0; ins_valid_i = 1'b0;
    exp_miss("R10 flush wins", rpc(5, 1));
    exp_miss("R10 flush old", dpc(70, 13));

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule